// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block sits between an 8-bit processor core and its external pins. It turns each core request into one external machine cycle. The low address byte and the data byte share a single set of pins, so the block puts the address on them first. It marks that address with a latch-enable pulse and then turns the same pins over to data. Alongside, it drives a high address byte, a two-bit status code, active-low read and write strobes, and a memory-versus-I/O select.

The core places a request with a cycle type, an address and write data. It holds the request until a one-clock done pulse comes back, and read data comes with that pulse. A slow device stretches a cycle by holding the ready input low. Another bus master can ask for the bus through a hold request. The block grants it only between machine cycles, floats its pins while the grant lasts, and takes them back half a clock after the grant drops. A halt request parks the bus with floated pins until the core withdraws it.

Top module: `muxbus_ctrl`

## Requirements
- R1: A cycle starts with one clock (T1) in which `ale` is high, `bus_ad` carries address bits 7:0 and `bus_ahi` carries address bits 15:8. `ale` is low in every other clock.
- R2: `status` shows the latched cycle type from T1 until the next cycle starts. The codes are: fetch (`req_type` 0) gives 11, memory read (1) and I/O read (3) give 10, memory write (2) and I/O write (4) give 01, and halt (5) gives 00.
- R3: In a read, `rd_n` goes low when T2 begins and returns high at the falling clock edge in the middle of T3. The block does not drive `bus_ad` from T2 to the end of T3. The byte on `bus_ad` at the rising edge of `rd_n` appears on `rd_data` while `req_done` is high. `req_done` is high for exactly one clock.
- R4: In a write, `wr_n` has the same low window as `rd_n` in R3. `req_wdata` is on `bus_ad` from T2 until the end of T3, which is after `wr_n` has risen.
- R5: `ready` is sampled at each rising edge that ends T2 or a wait clock. Each low sample adds one wait clock. With N low samples, `req_done` is seen after the (3+N)-th rising edge that follows the edge that accepts the request.
- R6: `io_m` is 1 for I/O cycles (types 3 and 4) and 0 for memory cycles. In an I/O cycle, address bits 7:0 (the port number) appear on both `bus_ad` and `bus_ahi` during T1.
- R7: `hold_req` is granted only when the block is idle or halted, or at the edge that ends T3 (the same edge that raises `req_done`). While `hlda` is high, no new cycle starts, even if a request is pending.
- R8: From the rising edge after the one that raised `hlda`, if `hold_req` is still high, `bus_ahi`, `bus_ad`, `rd_n`, `wr_n` and `io_m` are floated. `ale` and `status` stay driven.
- R9: When `hold_req` goes low, `hlda` falls at the next rising edge. The pins stay floated until the following falling edge and are driven again from then on.
- R10: A halt request (type 5, or a reserved type 6 or 7) parks the block. In that state `status` is 00, `ale` is low, no `req_done` is issued, and the pins of R8 are floated. The block leaves the halt at the first edge that sees the request withdrawn. A hold can be granted during the halt.
- R11: After a clock edge with `rst_n` low, the block is idle with `ale`=0, `rd_n`=`wr_n`=1, `hlda`=0 and `req_done`=0. Its address pins are driven with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core request present; held until `req_done` |
| req_type | input | 3 | Cycle type code (see R2) |
| req_addr | input | ADDR_W | Cycle address; bits 7:0 are the port for I/O |
| req_wdata | input | DATA_W | Write data |
| req_done | output | 1 | One-clock pulse when a cycle finishes |
| rd_data | output | DATA_W | Byte captured by a read cycle |
| ready | input | 1 | Low inserts wait clocks |
| hold_req | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus grant to the other master |
| bus_ahi | output | ADDR_W-DATA_W | High address byte, floatable |
| bus_ad | inout | DATA_W | Shared low address / data lines |
| ale | output | 1 | Address latch enable, never floated |
| status | output | 2 | Cycle status code |
| rd_n | output | 1 | Read strobe, active low, floatable |
| wr_n | output | 1 | Write strobe, active low, floatable |
| io_m | output | 1 | 1 = I/O, 0 = memory, floatable |

## Verification
The bench builds the block with its defaults, ADDR_W=16 and DATA_W=8. At these widths the high byte is as wide as a port number, so R6 can be checked by comparing the two address bytes directly. Every floatable line has a pull-up in the bench. A floated pin therefore reads as all ones, and the test addresses are chosen with zero-rich bytes so that a floated pin and a driven one read differently. Quarter-clock and three-quarter-clock sample points inside T3 and after the grant drops show the falling-edge events of R3, R4 and R9.

// File: rtl/muxbus_pkg.sv
// Package muxbus_pkg
// Shared cycle and state types for the multiplexed bus controller, with
// helper functions that classify a cycle type.
// Assumes a 3-bit request code from the core; codes 6 and 7 act as halt.
package muxbus_pkg;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_HALT  = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HOLD,
        ST_HALT
    } st_e;

    // True for cycles that put data out on the shared lines
    function automatic logic cyc_writes(input cyc_e c);
        return (c == CYC_MWR) || (c == CYC_IOWR);
    endfunction

    // True for cycles aimed at the I/O space
    function automatic logic cyc_is_io(input cyc_e c);
        return (c == CYC_IORD) || (c == CYC_IOWR);
    endfunction

    // Two-bit status code for a cycle type
    function automatic logic [1:0] cyc_status(input cyc_e c);
        case (c)
            CYC_FETCH:          return 2'b11;
            CYC_MRD, CYC_IORD:  return 2'b10;
            CYC_MWR, CYC_IOWR:  return 2'b01;
            default:            return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
// Module muxbus_seq
// Machine-cycle sequencer. It accepts a core request when idle, latches the
// type, address and write data, and steps through T1, T2, the wait clocks
// and T3. It also handles the halt park and the hold grant between cycles.
// Assumes the core keeps req_valid steady until req_done, and that
// ADDR_W > DATA_W.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold_req,
    output st_e               st,
    output cyc_e              cyc,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              hlda,
    output logic              done
);

    localparam int HI_W = ADDR_W - DATA_W;

    st_e               st_q;
    st_e               st_d;
    cyc_e              cyc_q;
    logic [ADDR_W-1:0] io_addr;
    logic              req_halt;
    logic              take;

    // Place the port number in both address bytes for I/O cycles
    generate
        if (HI_W == DATA_W) begin : g_io_same
            assign io_addr = {req_addr[DATA_W-1:0], req_addr[DATA_W-1:0]};
        end else if (HI_W < DATA_W) begin : g_io_narrow
            assign io_addr = {req_addr[HI_W-1:0], req_addr[DATA_W-1:0]};
        end else begin : g_io_wide
            assign io_addr = {{(HI_W-DATA_W){1'b0}}, req_addr[DATA_W-1:0],
                              req_addr[DATA_W-1:0]};
        end
    endgenerate

    assign req_halt = (req_type >= 3'd5);
    assign take     = (st_q == ST_IDLE) && !hold_req && req_valid && !done;

    // Next machine state
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (hold_req)      st_d = ST_HOLD;
                else if (take)     st_d = req_halt ? ST_HALT : ST_T1;
            end
            ST_T1:   st_d = ST_T2;
            ST_T2:   st_d = ready ? ST_T3 : ST_TW;
            ST_TW:   st_d = ready ? ST_T3 : ST_TW;
            ST_T3:   st_d = hold_req ? ST_HOLD : ST_IDLE;
            ST_HOLD: st_d = hold_req ? ST_HOLD : ST_IDLE;
            ST_HALT: begin
                if (hold_req)                   st_d = ST_HOLD;
                else if (req_valid && req_halt) st_d = ST_HALT;
                else                            st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st_q <= st_d;
            done <= (st_q == ST_T3);
        end
    end

    // Latch the request fields when a cycle is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= CYC_HALT;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            cyc_q   <= req_halt ? CYC_HALT : cyc_e'(req_type);
            addr_q  <= cyc_is_io(cyc_e'(req_type)) ? io_addr : req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign st   = st_q;
    assign cyc  = cyc_q;
    assign hlda = (st_q == ST_HOLD);

    // R5: a wait clock exists only after a low ready sample
    a_r5_wait_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TW) |-> !$past(ready));

    // R7: the grant rises only at a cycle boundary
    a_r7_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> ($past(st_q) inside {ST_IDLE, ST_T3, ST_HALT}));

    // R3: done lasts a single clock
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/muxbus_phase.sv
// Module muxbus_phase
// Half-clock timing. On the falling edge it cuts the strobes in the middle
// of T3, captures read data at that instant, and stretches the hold float
// by half a clock after the grant ends.
// Assumes that clk has a roughly even duty cycle.
module muxbus_phase
    import muxbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               st,
    input  cyc_e              cyc,
    input  logic              hold_req,
    input  logic [DATA_W-1:0] ad_in,
    output logic              strobe_cut,
    output logic [DATA_W-1:0] rd_data,
    output logic              float_hold
);

    logic p_float;
    logic n_float;

    // Rising-edge float request: set on the second clock of a held grant
    always_ff @(posedge clk) begin
        if (!rst_n) p_float <= 1'b0;
        else        p_float <= (st == ST_HOLD) && hold_req;
    end

    // Falling-edge strobe cut, read capture and float tail
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            strobe_cut <= 1'b0;
            rd_data    <= '0;
            n_float    <= 1'b0;
        end else begin
            strobe_cut <= (st == ST_T3);
            n_float    <= p_float;
            if (st == ST_T3 && !cyc_writes(cyc))
                rd_data <= ad_in;
        end
    end

    assign float_hold = p_float | n_float;

    // R8: a grant held over two edges keeps the pins floated
    a_r8_float_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> float_hold);

endmodule

// File: rtl/muxbus_pins.sv
// Module muxbus_pins
// Pin value and enable generation. It decodes the machine state into the
// latch enable, the status code, the strobes and the value on the shared
// lines, and it gives output enables to the tristate drivers in the top.
// Assumes that the strobe cut flag comes from the falling-edge logic.
module muxbus_pins
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  st_e                      st,
    input  cyc_e                     cyc,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic                     strobe_cut,
    input  logic                     float_hold,
    output logic [ADDR_W-DATA_W-1:0] ahi_val,
    output logic [DATA_W-1:0]        ad_val,
    output logic                     ad_oe,
    output logic                     ctl_oe,
    output logic                     ale,
    output logic [1:0]               status,
    output logic                     rd_n_val,
    output logic                     wr_n_val,
    output logic                     io_m_val
);

    logic in_data;
    logic strobe_on;
    logic writes;

    // Data phase and strobe window decode
    always_comb begin
        writes    = cyc_writes(cyc);
        in_data   = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
        strobe_on = in_data && !((st == ST_T3) && strobe_cut);
    end

    // Pin values and enables
    always_comb begin
        ale      = (st == ST_T1);
        status   = cyc_status(cyc);
        ctl_oe   = !(float_hold || (st == ST_HALT));
        ad_oe    = ctl_oe && !(in_data && !writes);
        ad_val   = in_data ? wdata_q : addr_q[DATA_W-1:0];
        ahi_val  = addr_q[ADDR_W-1:DATA_W];
        rd_n_val = !(strobe_on && !writes);
        wr_n_val = !(strobe_on && writes);
        io_m_val = cyc_is_io(cyc);
    end

    // R1: the latch enable lasts one clock
    a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4: write data is still driven and unchanged when the write strobe rises
    a_r4_data_through_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_val) |-> (ad_oe && $stable(ad_val)));

    // R10: halt shows status 00 with the pins floated
    a_r10_halt_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> (status == 2'b00 && !ctl_oe));

endmodule

// File: rtl/muxbus_ctrl.sv
// Module muxbus_ctrl
// Top of the multiplexed bus cycle controller. It joins the sequencer, the
// half-clock timing and the pin decode, and it owns the tristate drivers.
// Assumes one core request at a time, held until req_done.
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_type,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_done,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     ready,
    input  logic                     hold_req,
    output logic                     hlda,
    output logic [ADDR_W-DATA_W-1:0] bus_ahi,
    inout  wire  [DATA_W-1:0]        bus_ad,
    output logic                     ale,
    output logic [1:0]               status,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m
);

    localparam int HI_W = ADDR_W - DATA_W;

    st_e               st;
    cyc_e              cyc;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              strobe_cut;
    logic              float_hold;
    logic [HI_W-1:0]   ahi_val;
    logic [DATA_W-1:0] ad_val;
    logic              ad_oe;
    logic              ctl_oe;
    logic              rd_n_val;
    logic              wr_n_val;
    logic              io_m_val;

    muxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_type  (req_type),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .hold_req  (hold_req),
        .st        (st),
        .cyc       (cyc),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .hlda      (hlda),
        .done      (req_done)
    );

    muxbus_phase #(.DATA_W(DATA_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .cyc        (cyc),
        .hold_req   (hold_req),
        .ad_in      (bus_ad),
        .strobe_cut (strobe_cut),
        .rd_data    (rd_data),
        .float_hold (float_hold)
    );

    muxbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .cyc        (cyc),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .strobe_cut (strobe_cut),
        .float_hold (float_hold),
        .ahi_val    (ahi_val),
        .ad_val     (ad_val),
        .ad_oe      (ad_oe),
        .ctl_oe     (ctl_oe),
        .ale        (ale),
        .status     (status),
        .rd_n_val   (rd_n_val),
        .wr_n_val   (wr_n_val),
        .io_m_val   (io_m_val)
    );

    // Tristate drivers for the floatable pins
    assign bus_ahi = ctl_oe ? ahi_val  : 'z;
    assign bus_ad  = ad_oe  ? ad_val   : 'z;
    assign rd_n    = ctl_oe ? rd_n_val : 1'bz;
    assign wr_n    = ctl_oe ? wr_n_val : 1'bz;
    assign io_m    = ctl_oe ? io_m_val : 1'bz;

endmodule

// File: tb/muxbus_ctrl_tb.sv
module muxbus_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_type;
    logic [15:0] req_addr;
    logic [7:0] req_wdata;
    logic       req_done;
    logic [7:0] rd_data;
    logic       ready;
    logic       hold_req;
    logic       hlda;
    logic       ale;
    logic [1:0] status;
    wire  [7:0] ahi_w;
    wire  [7:0] ad_w;
    wire        rd_w;
    wire        wr_w;
    wire        iom_w;
    logic [7:0] tb_drv;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (ahi_w[i]);
        pullup (ad_w[i]);
    end
    pullup (rd_w);
    pullup (wr_w);
    pullup (iom_w);

    // Device model: answers a read while the read strobe is low
    assign ad_w = (rd_w == 1'b0) ? tb_drv : 8'bz;

    muxbus_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_type  (req_type),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_done  (req_done),
        .rd_data   (rd_data),
        .ready     (ready),
        .hold_req  (hold_req),
        .hlda      (hlda),
        .bus_ahi   (ahi_w),
        .bus_ad    (ad_w),
        .ale       (ale),
        .status    (status),
        .rd_n      (rd_w),
        .wr_n      (wr_w),
        .io_m      (iom_w)
    );

    task automatic chk(input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] exp_status(input logic [2:0] t);
        case (t)
            3'd0:       return 2'b11;
            3'd1, 3'd3: return 2'b10;
            3'd2, 3'd4: return 2'b01;
            default:    return 2'b00;
        endcase
    endfunction

    // One full cycle with N wait clocks; checks R1..R6
    task automatic run_cycle(input logic [2:0] t, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rdv,
                             input int waits);
        logic io;
        logic wr;
        int   edges;
        int   low_left;
        io = (t == 3'd3) || (t == 3'd4);
        wr = (t == 3'd2) || (t == 3'd4);
        req_type = t; req_addr = a; req_wdata = wd; tb_drv = rdv;
        req_valid = 1'b1; ready = 1'b1;
        step();
        chk("R1", "ale in T1", 16'(ale), 16'd1);
        chk("R1", "low address", 16'(ad_w), 16'(a[7:0]));
        chk(io ? "R6" : "R1", "high address", 16'(ahi_w), io ? 16'(a[7:0]) : 16'(a[15:8]));
        chk("R2", "status in T1", 16'(status), 16'(exp_status(t)));
        chk("R6", "io_m", 16'(iom_w), 16'(io));
        step();
        chk("R1", "ale after T1", 16'(ale), 16'd0);
        if (wr) begin
            chk("R4", "wr_n in T2", 16'(wr_w), 16'd0);
            chk("R4", "data in T2", 16'(ad_w), 16'(wd));
        end else begin
            chk("R3", "rd_n in T2", 16'(rd_w), 16'd0);
        end
        low_left = waits;
        ready = (low_left > 0) ? 1'b0 : 1'b1;
        edges = 1;
        while (!req_done && edges < 40) begin
            step();
            edges++;
            if (ready == 1'b0) low_left--;
            ready = (low_left > 0) ? 1'b0 : 1'b1;
            if (edges == 2 + waits) begin
                if (wr) begin
                    chk("R4", "wr_n early T3", 16'(wr_w), 16'd0);
                    #6;
                    chk("R4", "wr_n mid T3", 16'(wr_w), 16'd1);
                    chk("R4", "data after wr_n rise", 16'(ad_w), 16'(wd));
                end else begin
                    chk("R3", "rd_n early T3", 16'(rd_w), 16'd0);
                    #6;
                    chk("R3", "rd_n mid T3", 16'(rd_w), 16'd1);
                end
            end
        end
        chk("R5", "edges to done", 16'(edges), 16'(3 + waits));
        chk("R2", "status at done", 16'(status), 16'(exp_status(t)));
        if (!wr) chk("R3", "read data", 16'(rd_data), 16'(rdv));
        req_valid = 1'b0;
        ready = 1'b1;
        step();
        chk("R3", "done single clock", 16'(req_done), 16'd0);
        chk("R1", "ale idle", 16'(ale), 16'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_type = 3'd0; req_addr = '0;
        req_wdata = '0; ready = 1'b1; hold_req = 1'b0; tb_drv = 8'h00;
        step(); step();
        chk("R11", "ale", 16'(ale), 16'd0);
        chk("R11", "rd_n", 16'(rd_w), 16'd1);
        chk("R11", "wr_n", 16'(wr_w), 16'd1);
        chk("R11", "hlda", 16'(hlda), 16'd0);
        chk("R11", "done", 16'(req_done), 16'd0);
        chk("R11", "high address driven", 16'(ahi_w), 16'h00);
        rst_n = 1'b1;
        step();
    endtask

    // Hold raised mid-cycle, then a request pending during the grant
    task automatic t_hold();
        req_type = 3'd1; req_addr = 16'h3400; tb_drv = 8'h77; req_valid = 1'b1;
        step();
        hold_req = 1'b1;
        chk("R7", "no grant in T1", 16'(hlda), 16'd0);
        step();
        chk("R7", "no grant in T2", 16'(hlda), 16'd0);
        ready = 1'b0;
        step();
        ready = 1'b1;
        chk("R7", "no grant in wait", 16'(hlda), 16'd0);
        step();
        chk("R7", "no grant in T3", 16'(hlda), 16'd0);
        step();
        chk("R7", "grant with done", 16'(hlda), 16'd1);
        chk("R3", "done before grant", 16'(req_done), 16'd1);
        chk("R3", "read data", 16'(rd_data), 16'h77);
        chk("R8", "still driven on grant clock", 16'(ahi_w), 16'h34);
        req_type = 3'd2; req_addr = 16'h5600; req_wdata = 8'h0f;
        step();
        chk("R8", "high address floated", 16'(ahi_w), 16'hff);
        chk("R8", "shared lines floated", 16'(ad_w), 16'hff);
        chk("R8", "io_m floated", 16'(iom_w), 16'd1);
        chk("R8", "status driven", 16'(status), 16'b10);
        chk("R8", "ale driven low", 16'(ale), 16'd0);
        step();
        chk("R7", "no cycle during grant", 16'(ale), 16'd0);
        hold_req = 1'b0;
        step();
        chk("R9", "grant drops", 16'(hlda), 16'd0);
        chk("R9", "float before falling edge", 16'(ahi_w), 16'hff);
        #6;
        chk("R9", "driven after falling edge", 16'(ahi_w), 16'h34);
        step();
        chk("R7", "pending write starts", 16'(ale), 16'd1);
        chk("R7", "pending write address", 16'(ahi_w), 16'h56);
        while (!req_done) step();
        req_valid = 1'b0;
        step();
    endtask

    // Halt park, hold during halt, and plain exit
    task automatic t_halt();
        req_type = 3'd5; req_addr = 16'h2200; req_valid = 1'b1;
        step();
        chk("R10", "halt status", 16'(status), 16'b00);
        chk("R10", "halt float", 16'(ahi_w), 16'hff);
        chk("R10", "halt ale", 16'(ale), 16'd0);
        step();
        chk("R10", "no done in halt", 16'(req_done), 16'd0);
        hold_req = 1'b1;
        step();
        chk("R10", "grant from halt", 16'(hlda), 16'd1);
        hold_req = 1'b0; req_valid = 1'b0;
        step();
        chk("R9", "grant drops after halt", 16'(hlda), 16'd0);
        #6;
        chk("R10", "driven after leaving", 16'(ahi_w), 16'h22);
        req_type = 3'd6; req_valid = 1'b1;
        step();
        chk("R10", "reserved code halts", 16'(ahi_w), 16'hff);
        req_valid = 1'b0;
        step();
        chk("R10", "exit on withdraw", 16'(ahi_w), 16'h22);
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run_cycle(3'd0, 16'h1000, 8'h00, 8'h3e, 0);
        run_cycle(3'd1, 16'h0080, 8'h00, 8'hc5, 3);
        run_cycle(3'd2, 16'h2001, 8'h5a, 8'h00, 2);
        run_cycle(3'd3, 16'hab3c, 8'h00, 8'h91, 1);
        run_cycle(3'd4, 16'h0042, 8'ha6, 8'h00, 0);
        t_hold();
        t_halt();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule